// File: doc/BRIEF.md
# Cascaded Serial DAC Write Controller

This block is the host side of a three-wire serial link that drives a chain of 10-bit voltage-output DACs. The devices are wired in series: the host output feeds the first device, and each device's serial output feeds the next. A single start strobe takes one 10-bit code per device from a parallel bus. The block wraps each code into a 16-bit device word. It shifts the whole chain out in one chip-select window, with the serial clock idling low. It then raises chip select once, so every device latches its word on that common edge.

The serial clock half-period is a whole number of system clocks, set by a parameter. Every clock phase, the lead time from chip select to the first rising edge, the tail time after the last falling edge, and the chip-select high gap all take exactly one half-period. An optional check compares the bits that come back from the end of the chain during a frame against the words sent in the frame before. It raises a flag on any difference.

Top module: `dac_chain_host`

## Requirements
- R1: Each device word is 16 bits and is sent MSB first. Word bits 15..12 are 0, bits 11..2 carry the 10-bit code with its MSB at bit 11, and bits 1..0 are 0.
- R2: Device k takes its code from `codes[10k+9:10k]`. Device 0 sits next to the host and device N_DEV-1 is farthest away. The farthest device's word goes out first and device 0's word goes out last, so after the latch each device holds its own code.
- R3: `mosi` changes only while `sclk` is low and is stable for every system cycle in which `sclk` is high (clock polarity 0, phase 0).
- R4: `sclk` is low whenever `cs_n` is high. `cs_n` changes only while `sclk` is low and was low in the cycle before.
- R5: While `cs_n` is low, every high phase and every low phase of `sclk` lasts exactly HALF_DIV system clocks. Each frame has exactly 16*N_DEV rising edges.
- R6: `cs_n` falls one half-period before the first rising edge and rises one half-period after the last falling edge. It then stays high for at least one half-period before `done`.
- R7: An accepted start sets `busy` in the next cycle. `done` is a one-cycle pulse that arrives (32*N_DEV+2)*HALF_DIV cycles after the start edge. `busy` is low from that cycle on.
- R8: A `start` seen while `busy` is high is ignored: it neither changes the frame in progress nor begins another one.
- R9: `verify_en` is captured when a frame starts. If it is set and an earlier frame exists, `miso` is sampled at each rising `sclk` edge and compared with the same bit position of the previous frame. `mismatch` clears at each accepted start and, once set by a difference, holds until the next start. Without an earlier frame, or with `verify_en` low, `mismatch` stays 0.
- R10: After reset `cs_n`=1, `sclk`=0, `mosi`=0, `busy`=0, `done`=0 and `mismatch`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request to send one frame |
| codes | input | 10*N_DEV | One 10-bit code per device, device 0 in the lowest bits |
| verify_en | input | 1 | Compare returned bits with the previous frame |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle pulse after the latch edge and gap |
| mismatch | output | 1 | Returned data differed from the previous frame |
| sclk | output | 1 | Serial clock, idle low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the first device |
| miso | input | 1 | Serial data returned from the last device |

## Verification
With H = HALF_DIV, a start sampled at edge E0 drops `cs_n` at E0 and raises `sclk` at E0+H. After that `sclk` toggles every H edges. `cs_n` rises at E0+(32N+1)H, and `done` with `mismatch` final shows after E0+(32N+2)H. The bench drives inputs on falling system-clock edges and counts falling edges from the start pulse, so it expects `done` on exactly the (32N+2)H+1-th one. A monitor that samples on falling edges measures every `sclk` phase against H, captures `mosi` at each rise, and compares the captured stream and the codes latched by a shift-chain device model with values rebuilt from R1 and R2.

// File: rtl/dcx_pkg.sv
package dcx_pkg;
  localparam int WORD_W = 16;
  localparam int CODE_W = 10;
  localparam int PAD_LO = 2;
  localparam int PAD_HI = WORD_W - CODE_W - PAD_LO;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO,
    ST_HI,
    ST_TAIL,
    ST_GAP
  } seq_state_t;

  // Device word: zero head, code, zero tail.
  function automatic logic [WORD_W-1:0] fmt_word(input logic [CODE_W-1:0] code);
    fmt_word = {{PAD_HI{1'b0}}, code, {PAD_LO{1'b0}}};
  endfunction

  // System cycles from the start edge to the done pulse.
  function automatic int frame_cycles(input int n_dev, input int half_div);
    frame_cycles = (2 * WORD_W * n_dev + 2) * half_div;
  endfunction
endpackage

// File: rtl/dcx_halftick.sv
module dcx_halftick #(
  parameter int HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   cnt <= '0;
    else if (!run || cnt == LAST) cnt <= '0;
    else                          cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/dcx_seq.sv
module dcx_seq
  import dcx_pkg::*;
#(
  parameter int TOT_BITS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                tick,
  input  logic [TOT_BITS-1:0] frame_bits,
  output logic                busy,
  output logic                load,
  output logic                sample,
  output logic                sclk,
  output logic                cs_n,
  output logic                mosi,
  output logic                done
);
  localparam int BW = $clog2(TOT_BITS);
  localparam logic [BW-1:0] LAST_BIT = BW'(TOT_BITS - 1);

  seq_state_t          state;
  logic [TOT_BITS-1:0] sr;
  logic [BW-1:0]       bit_cnt;
  logic                last_bit;

  assign busy     = (state != ST_IDLE);
  assign load     = start && !busy;
  assign sample   = tick && (state == ST_LO);
  assign last_bit = (bit_cnt == LAST_BIT);
  assign mosi     = sr[TOT_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      sr      <= '0;
      bit_cnt <= '0;
      sclk    <= 1'b0;
      cs_n    <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          sr      <= frame_bits;
          bit_cnt <= '0;
          cs_n    <= 1'b0;
          state   <= ST_LO;
        end
        ST_LO: if (tick) begin
          sclk  <= 1'b1;
          state <= ST_HI;
        end
        ST_HI: if (tick) begin
          sclk <= 1'b0;
          sr   <= {sr[TOT_BITS-2:0], 1'b0};
          if (last_bit) state <= ST_TAIL;
          else begin
            bit_cnt <= bit_cnt + 1'b1;
            state   <= ST_LO;
          end
        end
        ST_TAIL: if (tick) begin
          cs_n  <= 1'b1;
          state <= ST_GAP;
        end
        ST_GAP: if (tick) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcx_echo.sv
module dcx_echo #(
  parameter int TOT_BITS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [TOT_BITS-1:0] frame_bits,
  input  logic                verify_en,
  input  logic                sample,
  input  logic                miso,
  output logic                mismatch
);
  logic [TOT_BITS-1:0] prev_bits;
  logic [TOT_BITS-1:0] exp_sr;
  logic                have_prev;
  logic                armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_bits <= '0;
      exp_sr    <= '0;
      have_prev <= 1'b0;
      armed     <= 1'b0;
      mismatch  <= 1'b0;
    end else if (load) begin
      exp_sr    <= prev_bits;
      prev_bits <= frame_bits;
      armed     <= verify_en && have_prev;
      have_prev <= 1'b1;
      mismatch  <= 1'b0;
    end else if (sample) begin
      exp_sr <= {exp_sr[TOT_BITS-2:0], 1'b0};
      if (armed && (miso != exp_sr[TOT_BITS-1])) mismatch <= 1'b1;
    end
  end
endmodule

// File: rtl/dac_chain_host.sv
module dac_chain_host
  import dcx_pkg::*;
#(
  parameter int N_DEV    = 2,
  parameter int HALF_DIV = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [N_DEV*CODE_W-1:0] codes,
  input  logic                    verify_en,
  output logic                    busy,
  output logic                    done,
  output logic                    mismatch,
  output logic                    sclk,
  output logic                    cs_n,
  output logic                    mosi,
  input  logic                    miso
);
  localparam int TOT_BITS = WORD_W * N_DEV;

  logic [TOT_BITS-1:0] frame_bits;
  logic                half_tick;
  logic                frame_load;
  logic                rise_sample;

  // Device N_DEV-1 occupies the top word so that it leaves first.
  for (genvar g = 0; g < N_DEV; g++) begin : g_word
    assign frame_bits[g*WORD_W +: WORD_W] = fmt_word(codes[g*CODE_W +: CODE_W]);
  end

  dcx_halftick #(.HALF_DIV(HALF_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(half_tick)
  );

  dcx_seq #(.TOT_BITS(TOT_BITS)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(half_tick),
    .frame_bits(frame_bits), .busy(busy), .load(frame_load),
    .sample(rise_sample), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .done(done)
  );

  dcx_echo #(.TOT_BITS(TOT_BITS)) u_echo (
    .clk(clk), .rst_n(rst_n), .load(frame_load), .frame_bits(frame_bits),
    .verify_en(verify_en), .sample(rise_sample), .miso(miso), .mismatch(mismatch)
  );
endmodule

// File: rtl/dac_chain_host_chk.sv
module dac_chain_host_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic sclk,
  input logic cs_n,
  input logic mosi,
  input logic tick
);
  p_idle_clock_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);

  p_cs_edge_clock_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != $past(cs_n)) |-> (!sclk && !$past(sclk)));

  p_data_steady_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi));

  p_clock_moves_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != $past(sclk)) |-> $past(tick));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $past(cs_n) && !busy));

  p_start_busy_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> !$fell(cs_n));
endmodule

bind dac_chain_host dac_chain_host_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .tick(half_tick)
);

// File: tb/dac_chain_host_test.sv
module dac_chain_host_test;
  localparam int CLK_PERIOD = 10;
  localparam int N = 2;
  localparam int H = 2;
  localparam int TOT = 16 * N;
  localparam int FRAME_NEG = (32 * N + 2) * H + 1;
  localparam int NVEC = 6;
  localparam logic [10*N-1:0] VEC [NVEC] = '{
    {10'h3FF, 10'h000}, {10'h000, 10'h3FF}, {10'h155, 10'h2AA},
    {10'h001, 10'h200}, {10'h2AA, 10'h155}, {10'h0F0, 10'h30F}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [10*N-1:0] codes = '0;
  logic verify_en = 1'b0;
  logic busy, done, mismatch, sclk, cs_n, mosi, miso;
  logic corrupt = 1'b0;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_chain_host #(.N_DEV(N), .HALF_DIV(H)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .codes(codes), .verify_en(verify_en),
    .busy(busy), .done(done), .mismatch(mismatch), .sclk(sclk), .cs_n(cs_n),
    .mosi(mosi), .miso(miso)
  );

  // Shift-chain stand-in for the cascaded devices.
  logic [15:0] dsr  [N];
  logic        ddout[N];
  logic        ddin [N];
  logic [9:0]  dlat [N];

  always_comb begin
    ddin[0] = mosi;
    for (int d = 1; d < N; d++) ddin[d] = ddout[d-1];
  end
  assign miso = corrupt ? ~ddout[N-1] : ddout[N-1];

  always @(posedge sclk or negedge rst_n)
    if (!rst_n) for (int d = 0; d < N; d++) dsr[d] <= '0;
    else if (!cs_n) for (int d = 0; d < N; d++) dsr[d] <= {dsr[d][14:0], ddin[d]};

  always @(negedge sclk or negedge rst_n)
    if (!rst_n) for (int d = 0; d < N; d++) ddout[d] <= 1'b0;
    else if (!cs_n) for (int d = 0; d < N; d++) ddout[d] <= dsr[d][15];

  always @(posedge cs_n or negedge rst_n)
    if (!rst_n) for (int d = 0; d < N; d++) dlat[d] <= '0;
    else for (int d = 0; d < N; d++) dlat[d] <= dsr[d][11:2];

  // Phase and stream monitor, sampled on falling system-clock edges.
  logic [TOT-1:0] cap = '0;
  int rises = 0, terr = 0, run_len = 0;
  logic lvl = 1'b0, in_fr = 1'b0;

  always @(negedge clk) begin
    if (!cs_n) begin
      if (!in_fr) begin
        in_fr = 1'b1; lvl = sclk; run_len = 1; cap = '0; rises = 0; terr = 0;
        if (sclk) terr++;
      end else if (sclk == lvl) run_len++;
      else begin
        if (run_len != H) terr++;
        if (sclk) begin cap = {cap[TOT-2:0], mosi}; rises++; end
        lvl = sclk; run_len = 1;
      end
    end else if (in_fr) begin
      if (run_len != H || lvl) terr++;
      in_fr = 1'b0;
    end
    if (cs_n && sclk) terr++;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [TOT-1:0] expect_stream(input logic [10*N-1:0] v);
    logic [TOT-1:0] s = '0;
    for (int d = N - 1; d >= 0; d--) s = (s << 16) | (TOT'(v[d*10 +: 10]) << 2);
    return s;
  endfunction

  // Sends one frame; optionally pulses start again in mid-frame.
  task automatic send(input logic [10*N-1:0] v, input bit ver, input bit bad,
                      input bit mid_start, output bit mm);
    int n;
    @(negedge clk);
    codes = v; verify_en = ver; corrupt = bad; start = 1'b1;
    @(negedge clk);
    start = 1'b0; n = 1;
    chk(busy === 1'b1, "R7", "busy after start", 64'(busy), 64'd1);
    while (!done && n < 5000) begin
      @(negedge clk); n++;
      if (mid_start && n == 40) begin codes = ~v; start = 1'b1; end
      else start = 1'b0;
    end
    mm = mismatch;
    chk(n == FRAME_NEG, "R7", "cycles to done", 64'(n), 64'(FRAME_NEG));
    chk(busy === 1'b0, "R7", "busy with done", 64'(busy), 64'd0);
    chk(terr == 0, "R5", "clock phase or cs timing faults (R4 R6)", 64'(terr), 64'd0);
    chk(rises == TOT, "R5", "rising edges per frame", 64'(rises), 64'(TOT));
    chk(cap == expect_stream(v), "R1", "serial stream (R2 R3)", 64'(cap), 64'(expect_stream(v)));
    for (int d = 0; d < N; d++)
      chk(dlat[d] == v[d*10 +: 10], "R2", "latched code", 64'(dlat[d]), 64'(v[d*10 +: 10]));
    @(negedge clk);
    chk(done === 1'b0, "R7", "done width", 64'(done), 64'd0);
    corrupt = 1'b0;
  endtask

  bit finished = 1'b0;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    bit mm;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n === 1'b1, "R10", "reset cs_n", 64'(cs_n), 64'd1);
    chk(sclk === 1'b0, "R10", "reset sclk", 64'(sclk), 64'd0);
    chk(mosi === 1'b0, "R10", "reset mosi", 64'(mosi), 64'd0);
    chk(busy === 1'b0 && done === 1'b0, "R10", "reset busy/done", 64'({busy, done}), 64'd0);
    chk(mismatch === 1'b0, "R10", "reset mismatch", 64'(mismatch), 64'd0);

    // R9: no earlier frame, so corrupted returns must not be flagged.
    send(10'h0AB << 10 | 20'h0CD, 1'b1, 1'b1, 1'b0, mm);
    chk(mm == 1'b0, "R9", "first frame not compared", 64'(mm), 64'd0);

    // Table of vectors; the chain echoes each previous frame faithfully.
    for (int i = 0; i < NVEC; i++) begin
      send(VEC[i], 1'b1, 1'b0, 1'b0, mm);
      chk(mm == 1'b0, "R9", "clean echo", 64'(mm), 64'd0);
    end

    // R8: start during a frame leaves it intact and starts nothing after it.
    send({10'h123, 10'h321}, 1'b0, 1'b0, 1'b1, mm);
    repeat (4 * H) @(negedge clk);
    chk(busy === 1'b0 && cs_n === 1'b1, "R8", "no extra frame", 64'({busy, cs_n}), 64'd1);

    // R9: corrupted echo with checking on, then off, then clean again.
    send({10'h2F0, 10'h00F}, 1'b1, 1'b1, 1'b0, mm);
    chk(mm == 1'b1, "R9", "corrupt echo flagged", 64'(mm), 64'd1);
    send({10'h111, 10'h222}, 1'b0, 1'b1, 1'b0, mm);
    chk(mm == 1'b0, "R9", "check disabled", 64'(mm), 64'd0);
    send({10'h3C3, 10'h03C}, 1'b1, 1'b0, 1'b0, mm);
    chk(mm == 1'b0, "R9", "flag cleared on start", 64'(mm), 64'd0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule